// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside the fetch stage of a small in-order core and runs counted loops without a branch at the end of the body. A loop-setup instruction gives it an iteration count, taken either from an 8-bit immediate that holds the count minus one or from the low half-word of a register. It also gives a forward offset that marks the first address past the body. From then on the controller watches each retiring instruction. When the instruction that leads into the end address retires, the controller either sends fetch back to the first body address or lets it fall through.

The core feeds the controller the address of the instruction that is retiring this cycle, together with that instruction's setup fields. It takes the override address whenever the override valid flag is high. The override is combinational with the retire strobe, so the redirect costs no bubble. A register count of zero skips the body: the controller redirects to the end address it currently holds. Only one loop level exists, and a new setup replaces whatever loop is running.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset the active flag is low and the stored start, end and count are zero, so a zero-count setup as the first loop instruction redirects to address 0.
- R2: With imm_sel_i high the iteration count is imm_i plus one: imm_i = 0 runs the body once and imm_i = 255 runs it 256 times.
- R3: With imm_sel_i low the count is reg_cnt_i. When it is zero, the setup cycle raises ovr_vld_o with ovr_pc_o equal to the stored loop end, and the active flag and loop registers keep their values.
- R4: A setup with a nonzero count stores start = pc_i + 1, end = pc_i + jmp_ofs_i (jmp_ofs_i zero-extended, sum modulo 2^PC_W) and the count. It sets active_o from the next cycle and raises no override in the setup cycle.
- R5: While active, a retire at an address pc_i with pc_i + 1 equal to the stored end decrements the count. If the count before the decrement was above one, ovr_vld_o is high in that same cycle with ovr_pc_o equal to the stored start.
- R6: On the pass where the count goes from one to zero, no override is raised, active_o falls on the next cycle, and execution falls through to the end address. A body of K-1 instructions with count N therefore retires N*(K-1) body instructions and is redirected N-1 times.
- R7: With retire_i and setup_i both low, ovr_vld_o is low and the loop state does not change.
- R8: A setup while a loop is active replaces the whole loop state. The old loop's end address then causes no redirect.
- R9: setup_i takes priority over the loop-end match in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| pc_i | input | PC_W | address of the instruction retiring this cycle |
| setup_i | input | 1 | retiring instruction is a loop setup |
| imm_sel_i | input | 1 | count comes from imm_i (high) or reg_cnt_i (low) |
| imm_i | input | IMM_W | immediate count minus one |
| reg_cnt_i | input | CNT_W | register count (low half-word) |
| jmp_ofs_i | input | OFS_W | offset from setup address to loop end |
| retire_i | input | 1 | an ordinary instruction retires at pc_i |
| ovr_pc_o | output | PC_W | fetch override address |
| ovr_vld_o | output | 1 | override is valid this cycle |
| active_o | output | 1 | a loop is running |

## Verification
The assertions assume that the core follows every override. They also assume that setup_i is used only with a loop offset of at least two, so the end address always lies past the setup instruction. The bench models the core's fetch as a sequencer that takes ovr_pc_o whenever it is valid and otherwise steps by one, so every retirement it drives obeys those assumptions. It sweeps offsets two to four against all small immediate and register counts and a few large ones. It also inserts idle cycles just before the end address and starts a new loop inside a running one.

// File: rtl/hwloop_pkg.sv
// Shared types for the hardware loop controller.
// Assumes: nothing beyond the standard types.
package hwloop_pkg;

    // Per-cycle action chosen by the controller.
    typedef enum logic [2:0] {
        ACT_NONE = 3'd0,  // no change
        ACT_SKIP = 3'd1,  // zero-count setup: jump to stored end
        ACT_LOAD = 3'd2,  // nonzero setup: load a new loop
        ACT_WRAP = 3'd3,  // end reached, iterations remain
        ACT_EXIT = 3'd4   // end reached, last iteration done
    } loop_act_e;

endpackage

// File: rtl/hwl_count_sel.sv
// Chooses the iteration count for a loop setup.
// The immediate carries count minus one; the register carries the count.
// Assumes: CNT_W > IMM_W so that immediate plus one cannot wrap.
module hwl_count_sel #(
    parameter int IMM_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             imm_sel_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [CNT_W-1:0] reg_cnt_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);
    localparam int PAD_W = CNT_W - IMM_W;

    logic [CNT_W-1:0] imm_ext;

    // Widen the immediate and add the implicit one.
    always_comb begin
        imm_ext = {{PAD_W{1'b0}}, imm_i} + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    // Select the source and flag a zero count.
    always_comb begin
        count_o = imm_sel_i ? imm_ext : reg_cnt_i;
        zero_o  = (count_o == '0);
    end
endmodule

// File: rtl/hwl_end_detect.sv
// Detects that the retiring instruction leads into the loop end address.
// Assumes: pc_i is the address of the instruction retiring this cycle.
module hwl_end_detect #(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] end_q,
    input  logic            active_q,
    input  logic            retire_i,
    output logic            hit_o
);
    localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

    logic [PC_W-1:0] seq_pc;

    // Sequential successor of the retiring address.
    always_comb begin
        seq_pc = pc_i + ONE;
    end

    // Match only for a live loop and a real retirement.
    always_comb begin
        hit_o = active_q && retire_i && (seq_pc == end_q);
    end
endmodule

// File: rtl/hwl_state.sv
// Holds the loop start, end, remaining count and active flag.
// Assumes: act_i is decoded by the parent and stable within the cycle.
module hwl_state
    import hwloop_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  loop_act_e        act_i,
    input  logic [PC_W-1:0]  new_start_i,
    input  logic [PC_W-1:0]  new_end_i,
    input  logic [CNT_W-1:0] new_cnt_i,
    output logic [PC_W-1:0]  start_q,
    output logic [PC_W-1:0]  end_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             active_q
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Address registers: written only by a loop load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (act_i == ACT_LOAD) begin
            start_q <= new_start_i;
            end_q   <= new_end_i;
        end
    end

    // Count and active flag: load, decrement or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else begin
            unique case (act_i)
                ACT_LOAD: begin
                    cnt_q    <= new_cnt_i;
                    active_q <= 1'b1;
                end
                ACT_WRAP: begin
                    cnt_q    <= cnt_q - CNT_ONE;
                end
                ACT_EXIT: begin
                    cnt_q    <= '0;
                    active_q <= 1'b0;
                end
                default: begin
                    cnt_q    <= cnt_q;
                    active_q <= active_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/hwloop_ctrl.sv
// Zero-overhead loop controller: one loop level, redirect in the retire cycle.
// Assumes: the core follows ovr_pc_o whenever ovr_vld_o is high, and
// loop offsets are at least two so the end lies beyond the setup.
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int CNT_W = 16,
    parameter int IMM_W = 8,
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             setup_i,
    input  logic             imm_sel_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [CNT_W-1:0] reg_cnt_i,
    input  logic [OFS_W-1:0] jmp_ofs_i,
    input  logic             retire_i,
    output logic [PC_W-1:0]  ovr_pc_o,
    output logic             ovr_vld_o,
    output logic             active_o
);
    localparam logic [PC_W-1:0]  PC_ONE  = {{(PC_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam int               OPAD_W  = PC_W - OFS_W;

    logic [CNT_W-1:0] setup_cnt;
    logic             setup_zero;
    logic             end_hit;
    logic [PC_W-1:0]  start_q;
    logic [PC_W-1:0]  end_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic [PC_W-1:0]  new_start;
    logic [PC_W-1:0]  new_end;
    loop_act_e        act;

    hwl_count_sel #(
        .IMM_W (IMM_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .imm_sel_i (imm_sel_i),
        .imm_i     (imm_i),
        .reg_cnt_i (reg_cnt_i),
        .count_o   (setup_cnt),
        .zero_o    (setup_zero)
    );

    hwl_end_detect #(
        .PC_W (PC_W)
    ) u_end (
        .pc_i     (pc_i),
        .end_q    (end_q),
        .active_q (active_q),
        .retire_i (retire_i),
        .hit_o    (end_hit)
    );

    // Addresses a nonzero setup would load.
    always_comb begin
        new_start = pc_i + PC_ONE;
        new_end   = pc_i + {{OPAD_W{1'b0}}, jmp_ofs_i};
    end

    // Action decode: setup first, then the loop-end match.
    always_comb begin
        if (setup_i) begin
            act = setup_zero ? ACT_SKIP : ACT_LOAD;
        end else if (end_hit) begin
            act = (cnt_q == CNT_ONE) ? ACT_EXIT : ACT_WRAP;
        end else begin
            act = ACT_NONE;
        end
    end

    hwl_state #(
        .PC_W  (PC_W),
        .CNT_W (CNT_W)
    ) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act),
        .new_start_i (new_start),
        .new_end_i   (new_end),
        .new_cnt_i   (setup_cnt),
        .start_q     (start_q),
        .end_q       (end_q),
        .cnt_q       (cnt_q),
        .active_q    (active_q)
    );

    // Fetch override and status outputs.
    always_comb begin
        ovr_vld_o = (act == ACT_SKIP) || (act == ACT_WRAP);
        ovr_pc_o  = (act == ACT_SKIP) ? end_q : start_q;
        active_o  = active_q;
    end
endmodule

// File: rtl/hwloop_ctrl_chk.sv
// Port-level property checker for hwloop_ctrl, attached by bind.
// Assumes: the core follows every override (see the brief).
module hwloop_ctrl_chk #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 16,
    parameter int IMM_W = 8,
    parameter int OFS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  pc_i,
    input logic             setup_i,
    input logic             imm_sel_i,
    input logic [IMM_W-1:0] imm_i,
    input logic [CNT_W-1:0] reg_cnt_i,
    input logic [OFS_W-1:0] jmp_ofs_i,
    input logic             retire_i,
    input logic [PC_W-1:0]  ovr_pc_o,
    input logic             ovr_vld_o,
    input logic             active_o
);
    logic            zero_setup;
    logic            live_setup;
    logic [PC_W-1:0] seen_start;

    // Classify a setup from the ports alone.
    always_comb begin
        zero_setup = setup_i && !imm_sel_i && (reg_cnt_i == '0);
        live_setup = setup_i && !zero_setup;
    end

    // Remember the body start announced at the last live setup.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_start <= '0;
        else if (live_setup) seen_start <= pc_i + {{(PC_W-1){1'b0}}, 1'b1};
    end

    // R7
    idle_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_i && !setup_i) |-> !ovr_vld_o);

    // R3
    zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_setup |-> ovr_vld_o);

    // R3
    zero_keeps_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_setup |=> (active_o == $past(active_o)));

    // R4
    load_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_setup |-> !ovr_vld_o);

    // R4
    load_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_setup |=> active_o);

    // R5
    wrap_needs_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_vld_o && !setup_i) |-> active_o);

    // R5
    wrap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_vld_o && !setup_i) |-> (ovr_pc_o == seen_start));

    // R6
    exit_only_on_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> $past(retire_i && !setup_i && !ovr_vld_o));
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(
    .PC_W  (PC_W),
    .CNT_W (CNT_W),
    .IMM_W (IMM_W),
    .OFS_W (OFS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_i      (pc_i),
    .setup_i   (setup_i),
    .imm_sel_i (imm_sel_i),
    .imm_i     (imm_i),
    .reg_cnt_i (reg_cnt_i),
    .jmp_ofs_i (jmp_ofs_i),
    .retire_i  (retire_i),
    .ovr_pc_o  (ovr_pc_o),
    .ovr_vld_o (ovr_vld_o),
    .active_o  (active_o)
);

// File: tb/sim_hwloop_ctrl.sv
`timescale 1ns/1ps
module sim_hwloop_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc = '0;
    logic        setup = 1'b0;
    logic        imm_sel = 1'b0;
    logic [7:0]  imm = '0;
    logic [15:0] regc = '0;
    logic [7:0]  ofs = '0;
    logic        retire = 1'b0;
    logic [15:0] ovr_pc;
    logic        ovr_vld;
    logic        active;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int last_end = 0;

    always #10 clk = ~clk;

    hwloop_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .pc_i (pc), .setup_i (setup),
        .imm_sel_i (imm_sel), .imm_i (imm), .reg_cnt_i (regc),
        .jmp_ofs_i (ofs), .retire_i (retire), .ovr_pc_o (ovr_pc),
        .ovr_vld_o (ovr_vld), .active_o (active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs after the falling edge and let them settle.
    task automatic drive(input logic [15:0] p, input bit su, input bit isel,
                         input int iv, input int rv, input int ov, input bit rt);
        @(negedge clk);
        pc = p; setup = su; imm_sel = isel; imm = iv[7:0];
        regc = rv[15:0]; ofs = ov[7:0]; retire = rt;
        #2;
    endtask

    // Set up one loop from an idle controller and run it to fall-through.
    task automatic run_loop(input int s, input int k, input bit use_imm,
                            input int immv, input int regv, input bit gaps);
        int exp_n = use_imm ? immv + 1 : regv;
        int body = 0;
        int wraps = 0;
        int guard = 0;
        int bad_tgt = 0;
        logic [15:0] p;
        drive(s[15:0], 1'b1, use_imm, immv, regv, k, 1'b1);
        if (exp_n == 0) begin
            chk(ovr_vld == 1'b1, "R3 skip valid", ovr_vld, 1);
            chk(ovr_pc == last_end[15:0], "R3 skip target", ovr_pc, last_end);
        end else begin
            chk(ovr_vld == 1'b0, "R4 no override at setup", ovr_vld, 0);
        end
        drive(s[15:0], 1'b0, 1'b0, 0, 0, 0, 1'b0);
        chk(active == (exp_n != 0), "R4 active after setup", active, exp_n != 0);
        if (exp_n == 0) return;
        last_end = s + k;
        p = s[15:0] + 16'd1;
        while (p != last_end[15:0] && guard < 150000) begin
            if (gaps && (p + 16'd1 == last_end[15:0])) begin
                drive(p, 1'b0, 1'b0, 0, 0, 0, 1'b0);
                chk(ovr_vld == 1'b0, "R7 idle cycle at end", ovr_vld, 0);
            end
            drive(p, 1'b0, 1'b0, 0, 0, 0, 1'b1);
            body++;
            guard++;
            if (ovr_vld) begin
                wraps++;
                if (ovr_pc != s[15:0] + 16'd1) bad_tgt++;
                p = ovr_pc;
            end else begin
                p = p + 16'd1;
            end
        end
        drive(p, 1'b0, 1'b0, 0, 0, 0, 1'b0);
        chk(bad_tgt == 0, "R5 redirect target", bad_tgt, 0);
        chk(body == exp_n * (k - 1), use_imm ? "R2 body count" : "R3 body count", body, exp_n * (k - 1));
        chk(wraps == exp_n - 1, "R5 redirect count", wraps, exp_n - 1);
        chk(active == 1'b0, "R6 active cleared", active, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int wraps;
        int other;
        logic [15:0] p;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk(active == 1'b0, "R1 active after reset", active, 0);
        chk(ovr_vld == 1'b0, "R7 no override idle", ovr_vld, 0);
        // R1: stored end is zero after reset
        run_loop(50, 3, 1'b0, 0, 0, 1'b0);

        // R2 / R3 / R5 / R6 sweeps
        for (int k = 2; k <= 4; k++) begin
            for (int i = 0; i <= 7; i++) run_loop(200 + k * 10, k, 1'b1, i, 0, k == 3);
            run_loop(300, k, 1'b1, 255, 0, 1'b0);
            for (int r = 0; r <= 5; r++) run_loop(400 + r, k, 1'b0, 0, r, k == 2);
            run_loop(600, k, 1'b0, 0, 300, 1'b1);
        end

        // R8 / R9: replace a running loop from inside its body
        drive(16'd100, 1'b1, 1'b1, 4, 0, 10, 1'b1);
        drive(16'd101, 1'b0, 1'b0, 0, 0, 0, 1'b1);
        drive(16'd102, 1'b1, 1'b0, 0, 2, 3, 1'b1);
        chk(ovr_vld == 1'b0, "R8 replacing setup", ovr_vld, 0);
        p = 16'd103; wraps = 0; other = 0;
        while (p != 16'd115) begin
            drive(p, 1'b0, 1'b0, 0, 0, 0, 1'b1);
            if (ovr_vld) begin
                if (ovr_pc == 16'd103) wraps++; else other++;
                p = ovr_pc;
            end else p = p + 16'd1;
        end
        drive(p, 1'b0, 1'b0, 0, 0, 0, 1'b0);
        chk(wraps == 1, "R8 new loop wraps", wraps, 1);
        chk(other == 0, "R8 old end ignored", other, 0);
        chk(active == 1'b0, "R8 inactive after new loop", active, 0);

        // R9: setup placed where the loop end would match
        drive(16'd700, 1'b1, 1'b1, 2, 0, 3, 1'b1);
        drive(16'd701, 1'b0, 1'b0, 0, 0, 0, 1'b1);
        drive(16'd702, 1'b1, 1'b1, 0, 0, 2, 1'b1);
        chk(ovr_vld == 1'b0, "R9 setup wins over end match", ovr_vld, 0);
        drive(16'd703, 1'b0, 1'b0, 0, 0, 0, 1'b1);
        chk(ovr_vld == 1'b0, "R9 new single pass", ovr_vld, 0);
        drive(16'd704, 1'b0, 1'b0, 0, 0, 0, 1'b0);
        chk(active == 1'b0, "R9 loop finished", active, 0);
        // R3: zero-count skip now targets the newest end 704
        drive(16'd800, 1'b1, 1'b0, 0, 0, 5, 1'b1);
        chk(ovr_pc == 16'd704, "R3 skip to latest end", ovr_pc, 704);
        drive(16'd704, 1'b0, 1'b0, 0, 0, 0, 1'b0);
        chk(active == 1'b0, "R3 skip leaves idle", active, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule